// File: doc/BRIEF.md
# Bi-Endian Byte-Lane Load/Store Unit

This block converts a processor's byte, halfword and word memory accesses into byte-lane traffic for a 32-bit memory bus. On that bus, lane k always carries the byte whose address has low bits k. Each request names its own byte order, so two back-to-back accesses may use different orders. Four orders are offered: plain little-endian; a big-endian order that keeps the data lanes and reverses the bytes of multi-byte values; a big-endian order that keeps whole words intact and mirrors the address of sub-word accesses; and a mixed order that swaps the two 16-bit halves of a word.

For a store the unit produces the word-aligned bus address, a 4-bit write strobe and the lane-placed write data. For a load the request also carries the 32-bit word read at that word address. The unit returns the selected bytes right-aligned, either sign-extended or zero-extended. An access whose alignment is wrong is flagged and has no effect on the bus. Requests enter on a valid/ready stream and results leave on another. A new request is taken when `req_valid` and `req_ready` are both high. A result is consumed when `rsp_valid` and `rsp_ready` are both high. With the default output register, `req_ready` is high whenever the output holds nothing or is being drained in that cycle. A stalled result stays frozen until it is consumed.

Top module: `lsu_lane_top`

## Requirements
- R1: Order code 0 (little-endian): value byte j of an access at offset o travels on lane o+j. Example: a word store of 0x0A0B0C0D at offset 0 gives write data 0x0A0B0C0D, and loads gather their bytes from the same lanes.
- R2: Order code 1 (byte-swapping big-endian): a byte access behaves as in R1. For an access of n bytes (n = 2 or 4), value byte j travels on lane o+n-1-j. Bytes move as whole units and their bits are never reordered. The word 0x0A0B0C0D at offset 0 gives write data 0x0D0C0B0A.
- R3: Order code 2 (word-keeping big-endian): a word access behaves as in R1. A byte access uses offset o XOR 3 and a halfword access uses offset o XOR 2, with little-endian placement from there.
- R4: Order code 3 (mixed): byte and halfword accesses behave as in R1. A word places value byte j on lane j XOR 2, so 0x0A0B0C0D lands as bytes 0B,0A,0D,0C on lanes 0..3, which gives write data 0x0C0D0A0B.
- R5: Size codes are 0 for byte, 1 for halfword and 2 for word. Code 3, a halfword at an odd offset, or a word at a nonzero offset raises `rsp_err`. When `rsp_err` is high, strobe, write data and load data are all zero.
- R6: For a legal store, `rsp_strb` marks exactly the lanes written and unwritten lanes carry zero data. Loads drive a zero strobe and zero write data, and stores return zero load data. `rsp_addr` is the request address with its two low bits cleared.
- R7: Loads of a byte or halfword are returned in the low bits. When `req_signed` is 1 they are sign-extended to 32 bits from their top bit; otherwise they are zero-extended.
- R8: The order is taken from each request on its own, and consecutive requests may use different orders.
- R9: `req_ready` is high exactly when `rsp_valid` is low or `rsp_ready` is high. A result reaches the output one cycle after it is accepted. While `rsp_valid` is high and `rsp_ready` is low, all outputs hold steady.
- R10: During reset `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| req_order | input | 2 | 0 LE, 1 byte-swapping BE, 2 word-keeping BE, 3 mixed |
| req_signed | input | 1 | Sign-extend narrow loads |
| req_wdata | input | 32 | Store value, right-aligned |
| req_rword | input | 32 | Memory word read at the word address (loads) |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result consumed this cycle when valid |
| rsp_addr | output | ADDR_W | Word-aligned bus address |
| rsp_strb | output | 4 | Byte-lane write strobe |
| rsp_wdata | output | 32 | Lane-placed write data |
| rsp_ldata | output | 32 | Right-aligned, extended load value |
| rsp_err | output | 1 | Illegal alignment or size |

## Verification
The two functions that can meet in one cycle are the stall of a finished result and the arrival of the next request, which may carry a different order. The bench holds `rsp_ready` low while a second request with a new order waits at the input. It checks that `req_ready` drops, that the first result stays unchanged for several cycles, and that the second result appears, converted in its own order, exactly one cycle after the stall is released. Every order, size, offset, direction and extension choice is also swept against an address-arithmetic model.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
  localparam int DATA_W  = 32;
  localparam int LANE_W  = 8;
  localparam int LANES   = DATA_W / LANE_W;
  localparam int LIDX_W  = $clog2(LANES);
  localparam int CNT_W   = LIDX_W + 1;

  typedef enum logic [1:0] {
    ORD_LE      = 2'd0,
    ORD_BE_SWAP = 2'd1,
    ORD_BE_WORD = 2'd2,
    ORD_MIXED   = 2'd3
  } order_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } size_e;

  typedef struct packed {
    logic [LANES-1:0]  strb;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] ldata;
    logic              err;
  } lane_rsp_t;

  function automatic logic [CNT_W-1:0] size_bytes(size_e sz);
    case (sz)
      SZ_BYTE: size_bytes = CNT_W'(1);
      SZ_HALF: size_bytes = CNT_W'(2);
      SZ_WORD: size_bytes = CNT_W'(4);
      default: size_bytes = '0;
    endcase
  endfunction

  // Relation between a lane position relative to the access start and the
  // value byte it carries. The map is its own inverse, so both directions use it.
  function automatic logic [LIDX_W-1:0] byte_perm(order_e ord, size_e sz,
                                                  logic [LIDX_W-1:0] rel);
    byte_perm = rel;
    if (ord == ORD_BE_SWAP && sz == SZ_HALF) byte_perm = {1'b0, ~rel[0]};
    if (ord == ORD_BE_SWAP && sz == SZ_WORD) byte_perm = ~rel;
    if (ord == ORD_MIXED   && sz == SZ_WORD) byte_perm = rel ^ 2'b10;
  endfunction
endpackage

// File: rtl/lsu_lane_decode.sv
module lsu_lane_decode
  import lsu_lane_pkg::*;
(
  input  logic [LIDX_W-1:0] ofs_i,
  input  size_e             size_i,
  input  order_e            order_i,
  output logic [LIDX_W-1:0] eff_ofs_o,
  output logic [CNT_W-1:0]  nbytes_o,
  output logic              misalign_o
);
  logic [LIDX_W-1:0] mirror;

  always_comb begin
    nbytes_o = size_bytes(size_i);
    case (size_i)
      SZ_BYTE: misalign_o = 1'b0;
      SZ_HALF: misalign_o = ofs_i[0];
      SZ_WORD: misalign_o = |ofs_i;
      default: misalign_o = 1'b1;
    endcase
    mirror = '0;
    if (order_i == ORD_BE_WORD) begin
      if (size_i == SZ_BYTE) mirror = 2'b11;
      else if (size_i == SZ_HALF) mirror = 2'b10;
    end
    eff_ofs_o = ofs_i ^ mirror;
  end
endmodule

// File: rtl/lsu_lane_store.sv
module lsu_lane_store
  import lsu_lane_pkg::*;
(
  input  logic              en_i,
  input  logic [LIDX_W-1:0] eff_ofs_i,
  input  logic [CNT_W-1:0]  nbytes_i,
  input  size_e             size_i,
  input  order_e            order_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [LANES-1:0]  strb_o,
  output logic [DATA_W-1:0] bus_wdata_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LIDX_W-1:0] rel;
    logic [LIDX_W-1:0] src;
    logic              hit;
    assign rel = LIDX_W'(k) - eff_ofs_i;
    assign hit = en_i && ({1'b0, rel} < nbytes_i);
    assign src = byte_perm(order_i, size_i, rel);
    assign strb_o[k] = hit;
    assign bus_wdata_o[k*LANE_W +: LANE_W] =
      hit ? wdata_i[{src, 3'b000} +: LANE_W] : '0;
  end
endmodule

// File: rtl/lsu_lane_load.sv
module lsu_lane_load
  import lsu_lane_pkg::*;
(
  input  logic              en_i,
  input  logic [LIDX_W-1:0] eff_ofs_i,
  input  size_e             size_i,
  input  order_e            order_i,
  input  logic              signed_i,
  input  logic [DATA_W-1:0] rword_i,
  output logic [DATA_W-1:0] ldata_o
);
  logic [LANES-1:0][LANE_W-1:0] vbyte;

  for (genvar j = 0; j < LANES; j++) begin : g_pick
    logic [LIDX_W-1:0] lane;
    assign lane = eff_ofs_i + byte_perm(order_i, size_i, LIDX_W'(j));
    assign vbyte[j] = rword_i[{lane, 3'b000} +: LANE_W];
  end

  always_comb begin
    ldata_o = '0;
    if (en_i) begin
      case (size_i)
        SZ_BYTE: ldata_o = {{(DATA_W-LANE_W){signed_i & vbyte[0][LANE_W-1]}}, vbyte[0]};
        SZ_HALF: ldata_o = {{(DATA_W-2*LANE_W){signed_i & vbyte[1][LANE_W-1]}},
                            vbyte[1], vbyte[0]};
        SZ_WORD: ldata_o = vbyte;
        default: ldata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/lsu_lane_top.sv
module lsu_lane_top
  import lsu_lane_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_store,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [1:0]        req_order,
  input  logic              req_signed,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] req_rword,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [LANES-1:0]  rsp_strb,
  output logic [DATA_W-1:0] rsp_wdata,
  output logic [DATA_W-1:0] rsp_ldata,
  output logic              rsp_err
);
  size_e             size;
  order_e            order;
  logic [LIDX_W-1:0] eff_ofs;
  logic [CNT_W-1:0]  nbytes;
  logic              misalign;
  lane_rsp_t         comb_rsp;
  logic [ADDR_W-1:0] comb_addr;

  assign size      = size_e'(req_size);
  assign order     = order_e'(req_order);
  assign comb_addr = {req_addr[ADDR_W-1:LIDX_W], {LIDX_W{1'b0}}};
  assign comb_rsp.err = misalign;

  lsu_lane_decode u_dec (
    .ofs_i     (req_addr[LIDX_W-1:0]),
    .size_i    (size),
    .order_i   (order),
    .eff_ofs_o (eff_ofs),
    .nbytes_o  (nbytes),
    .misalign_o(misalign)
  );

  lsu_lane_store u_st (
    .en_i       (req_store & ~misalign),
    .eff_ofs_i  (eff_ofs),
    .nbytes_i   (nbytes),
    .size_i     (size),
    .order_i    (order),
    .wdata_i    (req_wdata),
    .strb_o     (comb_rsp.strb),
    .bus_wdata_o(comb_rsp.wdata)
  );

  lsu_lane_load u_ld (
    .en_i     (~req_store & ~misalign),
    .eff_ofs_i(eff_ofs),
    .size_i   (size),
    .order_i  (order),
    .signed_i (req_signed),
    .rword_i  (req_rword),
    .ldata_o  (comb_rsp.ldata)
  );

  lane_rsp_t out_rsp;

  if (REG_OUT) begin : g_reg
    lane_rsp_t         rsp_q;
    logic [ADDR_W-1:0] addr_q;
    logic              vld_q;

    assign req_ready = ~vld_q | rsp_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        rsp_q  <= '0;
        addr_q <= '0;
      end else if (req_ready) begin
        vld_q <= req_valid;
        if (req_valid) begin
          rsp_q  <= comb_rsp;
          addr_q <= comb_addr;
        end
      end
    end

    assign rsp_valid = vld_q;
    assign out_rsp   = rsp_q;
    assign rsp_addr  = addr_q;
  end else begin : g_pass
    assign req_ready = rsp_ready;
    assign rsp_valid = req_valid;
    assign out_rsp   = comb_rsp;
    assign rsp_addr  = comb_addr;
  end

  assign rsp_strb  = out_rsp.strb;
  assign rsp_wdata = out_rsp.wdata;
  assign rsp_ldata = out_rsp.ldata;
  assign rsp_err   = out_rsp.err;
endmodule

// File: rtl/lsu_lane_chk.sv
module lsu_lane_chk #(
  parameter int ADDR_W  = 16,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic [3:0]        rsp_strb,
  input logic [31:0]       rsp_wdata,
  input logic [31:0]       rsp_ldata,
  input logic              rsp_err
);
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_strb == 4'b0 && rsp_wdata == 32'b0 && rsp_ldata == 32'b0); // R5

  AST_STRB_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones(rsp_strb) == 0 || $countones(rsp_strb) == 1 ||
                   $countones(rsp_strb) == 2 || $countones(rsp_strb) == 4)); // R6

  AST_WORD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_addr[1:0] == 2'b00); // R6

  AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R9

  if (REG_OUT) begin : g_reg_chk
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_strb) &&
                                  $stable(rsp_wdata) && $stable(rsp_ldata) && $stable(rsp_err)); // R9

    AST_WORD_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && req_size == 2'd2 && req_addr[1:0] != 2'b00
      |=> rsp_valid && rsp_err); // R5
  end
endmodule

bind lsu_lane_top lsu_lane_chk #(.ADDR_W(ADDR_W), .REG_OUT(REG_OUT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_addr (req_addr),
  .req_size (req_size),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_addr (rsp_addr),
  .rsp_strb (rsp_strb),
  .rsp_wdata(rsp_wdata),
  .rsp_ldata(rsp_ldata),
  .rsp_err  (rsp_err)
);

// File: tb/sim_lsu_lane_top.sv
module sim_lsu_lane_top;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready, req_store, req_signed;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_size, req_order;
  logic [31:0]   req_wdata, req_rword;
  logic          rsp_valid, rsp_ready, rsp_err;
  logic [AW-1:0] rsp_addr;
  logic [3:0]    rsp_strb;
  logic [31:0]   rsp_wdata, rsp_ldata;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  lsu_lane_top #(.ADDR_W(AW), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
    .req_addr(req_addr), .req_size(req_size), .req_order(req_order),
    .req_signed(req_signed), .req_wdata(req_wdata), .req_rword(req_rword),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
    .rsp_strb(rsp_strb), .rsp_wdata(rsp_wdata), .rsp_ldata(rsp_ldata),
    .rsp_err(rsp_err)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Lane (address offset within the word) holding value byte j.
  function automatic int lane_of(int ord, int sz, int a, int j);
    int n = 1 << sz;
    int o = a % 4;
    case (ord)
      0:       return (o + j) % 4;
      1:       return (o + n - 1 - j) % 4;
      2:       return ((o ^ (4 - n)) + j) % 4;
      default: return (n == 4) ? (o + (j ^ 2)) % 4 : (o + j) % 4;
    endcase
  endfunction

  task automatic drive(input bit st, input int a, input int sz, input int ord,
                       input bit sg, input logic [31:0] wd, input logic [31:0] rw);
    req_valid  = 1'b1;
    req_store  = st;
    req_addr   = AW'(a);
    req_size   = 2'(sz);
    req_order  = 2'(ord);
    req_signed = sg;
    req_wdata  = wd;
    req_rword  = rw;
  endtask

  task automatic sweep_one(input bit st, input int a, input int sz, input int ord,
                           input bit sg, input logic [31:0] wd, input logic [31:0] rw);
    logic [3:0]    e_strb = '0;
    logic [31:0]   e_wd = '0;
    logic [31:0]   e_ld = '0;
    logic          e_err;
    logic [AW-1:0] e_addr;
    logic [85:0]   act, exp;
    string         tag;
    int            n = 1 << sz;
    drive(st, a, sz, ord, sg, wd, rw);
    @(negedge clk);
    e_err  = (sz == 3) || ((a % 4) % n != 0);
    e_addr = AW'(a) & ~AW'(3);
    if (!e_err) begin
      for (int j = 0; j < n; j++) begin
        int l = lane_of(ord, sz, a, j);
        if (st) begin
          e_strb[l] = 1'b1;
          e_wd[8*l +: 8] = wd[8*j +: 8];
        end else begin
          e_ld[8*j +: 8] = rw[8*l +: 8];
        end
      end
      if (!st && sg && n < 4 && e_ld[8*n-1])
        for (int b = 8*n; b < 32; b++) e_ld[b] = 1'b1;
    end
    case (ord)
      0:       tag = "R1";
      1:       tag = "R2";
      2:       tag = "R3";
      default: tag = "R4";
    endcase
    if (e_err) tag = {tag, " R5 misaligned"};
    else if (st) tag = {tag, " R6 store lanes"};
    else tag = {tag, " R7 load extend"};
    act = {rsp_valid, rsp_err, rsp_strb, rsp_wdata, rsp_ldata, rsp_addr};
    exp = {1'b1, e_err, e_strb, e_wd, e_ld, e_addr};
    check(act === exp, tag, 128'(act), 128'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    rsp_ready = 1'b1;
    drive(1'b0, 0, 0, 0, 1'b0, 32'h0, 32'h0);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0 && req_ready == 1'b1, "R10 reset state",
          128'({rsp_valid, req_ready}), 128'(2'b01));
    rst_n = 1'b1;
    @(negedge clk);

    // Named examples from the requirements.
    drive(1'b1, 8, 2, 0, 1'b0, 32'h0A0B0C0D, 32'h0);
    @(negedge clk);
    check(rsp_wdata == 32'h0A0B0C0D && rsp_strb == 4'hF, "R1 word example",
          128'(rsp_wdata), 128'(32'h0A0B0C0D));
    drive(1'b1, 8, 2, 1, 1'b0, 32'h0A0B0C0D, 32'h0);
    @(negedge clk);
    check(rsp_wdata == 32'h0D0C0B0A, "R2 word example R8 order change",
          128'(rsp_wdata), 128'(32'h0D0C0B0A));
    drive(1'b1, 8, 2, 3, 1'b0, 32'h0A0B0C0D, 32'h0);
    @(negedge clk);
    check(rsp_wdata == 32'h0C0D0A0B, "R4 word example R8 order change",
          128'(rsp_wdata), 128'(32'h0C0D0A0B));
    drive(1'b1, 8, 0, 2, 1'b0, 32'h000000A5, 32'h0);
    @(negedge clk);
    check(rsp_strb == 4'b1000 && rsp_wdata == 32'hA5000000, "R3 byte mirror",
          128'({rsp_strb, rsp_wdata}), 128'({4'b1000, 32'hA5000000}));

    // Sweep every order, size, offset, direction and extension.
    for (int p = 0; p < 2; p++)
      for (int ord = 0; ord < 4; ord++)
        for (int sz = 0; sz < 4; sz++)
          for (int o = 0; o < 4; o++)
            for (int st = 0; st < 2; st++)
              for (int sg = 0; sg < 2; sg++)
                sweep_one(st[0], 32'h120 + 4*p + o, sz, ord, sg[0],
                          p ? 32'hC35A912E : 32'h7E19A4D3,
                          p ? 32'h8A7BF615 : 32'h15F68A7B);

    // Stall with a different-order request waiting behind it.
    drive(1'b1, 0, 2, 0, 1'b0, 32'h11223344, 32'h0);
    @(negedge clk);
    rsp_ready = 1'b0;
    drive(1'b1, 4, 2, 1, 1'b0, 32'h0A0B0C0D, 32'h0);
    #1;
    check(req_ready == 1'b0, "R9 ready low under stall", 128'(req_ready), 128'(0));
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check(rsp_valid && rsp_wdata == 32'h11223344 && rsp_addr == 16'h0,
            "R9 output held while stalled",
            128'({rsp_valid, rsp_wdata, rsp_addr}), 128'({1'b1, 32'h11223344, 16'h0}));
    end
    rsp_ready = 1'b1;
    #1;
    check(req_ready == 1'b1, "R9 ready with drain", 128'(req_ready), 128'(1));
    @(negedge clk);
    check(rsp_valid && rsp_wdata == 32'h0D0C0B0A && rsp_addr == 16'h4,
          "R8 queued request converted in its own order",
          128'({rsp_valid, rsp_wdata, rsp_addr}), 128'({1'b1, 32'h0D0C0B0A, 16'h4}));
    req_valid = 1'b0;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R9 empty after drain", 128'(rsp_valid), 128'(0));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule